// File: doc/BRIEF.md
# Full/Empty Tagged Synchronizing Memory

This block is a word-addressed memory in which every data word has a one-bit presence tag. The tag marks the word either full (1) or empty (0). Threads that share data use it for fine-grained producer/consumer handoff. A producer fills a word. A consumer takes the word, which empties it again. Each side traps when the word is not in the state it expects, and trap-handling software retries or reschedules the access.

A request carries an opcode, a word address and write data. The tag test, the tag update and the data write all happen on the clock edge that accepts the request, so a check cannot be separated from its update. The response comes one cycle later. It carries:
- the read data;
- a trap flag and a cause code;
- the four tags of the addressed line, as they stood before the access.

Words are grouped four to a line. The tags of a line are kept side by side, so all four can be read together.

Top module: `fe_sync_mem`

## Requirements
- R1: Every accepted request (`req_valid`=1 at a clock edge) produces exactly one response with `rsp_valid`=1 on the following cycle. `rsp_valid` is 0 in a cycle that follows an edge with no request.
- R2: While `rst` is high, and after it falls, `rsp_valid` and `rsp_trap` are 0 and every word's tag is empty.
- R3: Opcodes 0 (plain load) and 1 (plain store) never trap and never change any tag. Opcode 1 writes the data.
- R4: Opcode 2 (checked load) returns the word. It traps with cause 1 (empty) when the word's tag is 0. It never changes the tag.
- R5: Opcode 3 (taking load) traps with cause 1 when the word is empty. Otherwise it returns the word and clears its tag.
- R6: Opcode 4 (filling store) writes the data and sets the tag, whatever the tag held before, and never traps.
- R7: Opcode 5 (checked filling store) traps with cause 2 (full) when the word's tag is 1. Otherwise it writes the data and sets the tag.
- R8: An access that traps leaves the word's data and every tag unchanged.
- R9: `rsp_cause` is 0 whenever `rsp_trap` is 0, and nonzero whenever `rsp_trap` is 1.
- R10: `rsp_line_tags` returns the four tags of the addressed line as they were before the access. Bit k of this field is the tag of the word whose address ends in the two bits k.
- R11: Opcodes 6 and 7 are reserved. They never trap, report cause 0, and change neither data nor tags.
- R12: `rsp_rdata` returns the word's contents as they were before the access, for every opcode. A store therefore returns the value it replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Opcode (0..5 defined, 6..7 reserved) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | DATA_W | Word contents before the access |
| rsp_trap | output | 1 | Access condition failed; no state changed |
| rsp_cause | output | 2 | 0 none, 1 empty, 2 full |
| rsp_line_tags | output | 4 | Tags of the addressed line before the access |

## Verification
A wrong tag inside the block cannot be seen at once. It appears on the next access to that word or to any word in the same line: as a spurious trap, as a missing trap, or as a wrong bit in `rsp_line_tags`, always one cycle after that access. A lost or misdirected data write appears as stale `rsp_rdata` on the next access to the word, because the read-first port returns the previous contents even on a store. The stimulus therefore follows every state-changing access with an access to the same word. It also probes a neighbouring word of the same line and words at both ends of the address range, so that corruption of a tag or of a word surfaces within one or two cycles.

// File: rtl/fe_pkg.sv
package fe_pkg;

  typedef enum logic [2:0] {
    OP_LD          = 3'd0,
    OP_ST          = 3'd1,
    OP_LD_CHK      = 3'd2,
    OP_LD_TAKE     = 3'd3,
    OP_ST_FILL     = 3'd4,
    OP_ST_FILL_CHK = 3'd5,
    OP_RSV6        = 3'd6,
    OP_RSV7        = 3'd7
  } fe_op_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_EMPTY = 2'd1,
    CAUSE_FULL  = 2'd2
  } fe_cause_e;

  typedef struct packed {
    logic      trap;
    fe_cause_e cause;
    logic      data_we;
    logic      tag_we;
    logic      tag_val;
  } fe_action_t;

endpackage

// File: rtl/fe_data_ram.sv
module fe_data_ram #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // read-first single port: the read returns the word before this write
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/fe_tag_store.sv
module fe_tag_store #(
  parameter int LINE_AW = 4,
  parameter int SLOTS   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LINE_AW-1:0]       rd_line,
  output logic [SLOTS-1:0]         rd_tags,
  input  logic                     wr_en,
  input  logic [LINE_AW-1:0]       wr_line,
  input  logic [$clog2(SLOTS)-1:0] wr_slot,
  input  logic                     wr_val,
  output logic [(1<<LINE_AW)*SLOTS-1:0] flat
);
  localparam int LINES = 1 << LINE_AW;

  logic [SLOTS-1:0] line_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) line_q[i] <= '0;
    end else if (wr_en) begin
      line_q[wr_line][wr_slot] <= wr_val;
    end
  end

  assign rd_tags = line_q[rd_line];

  for (genvar g = 0; g < LINES; g++) begin : g_flat
    assign flat[g*SLOTS +: SLOTS] = line_q[g];
  end
endmodule

// File: rtl/fe_tag_policy.sv
module fe_tag_policy
  import fe_pkg::*;
(
  input  fe_op_e     op,
  input  logic       tag,
  output fe_action_t act
);
  always_comb begin
    act = '{trap: 1'b0, cause: CAUSE_NONE, data_we: 1'b0, tag_we: 1'b0, tag_val: 1'b0};
    unique case (op)
      OP_LD: ;
      OP_ST: act.data_we = 1'b1;
      OP_LD_CHK: begin
        if (!tag) begin
          act.trap  = 1'b1;
          act.cause = CAUSE_EMPTY;
        end
      end
      OP_LD_TAKE: begin
        if (!tag) begin
          act.trap  = 1'b1;
          act.cause = CAUSE_EMPTY;
        end else begin
          act.tag_we  = 1'b1;
          act.tag_val = 1'b0;
        end
      end
      OP_ST_FILL: begin
        act.data_we = 1'b1;
        act.tag_we  = 1'b1;
        act.tag_val = 1'b1;
      end
      OP_ST_FILL_CHK: begin
        if (tag) begin
          act.trap  = 1'b1;
          act.cause = CAUSE_FULL;
        end else begin
          act.data_we = 1'b1;
          act.tag_we  = 1'b1;
          act.tag_val = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem
  import fe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int SLOTS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_trap,
  output logic [1:0]        rsp_cause,
  output logic [SLOTS-1:0]  rsp_line_tags
);
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int LINE_AW = ADDR_W - SLOT_W;
  localparam int WORDS   = 1 << ADDR_W;

  logic [LINE_AW-1:0] line;
  logic [SLOT_W-1:0]  slot;
  logic [SLOTS-1:0]   line_tags;
  logic               cur_tag;
  logic [WORDS-1:0]   tag_flat;
  fe_action_t         act;

  assign line    = req_addr[ADDR_W-1:SLOT_W];
  assign slot    = req_addr[SLOT_W-1:0];
  assign cur_tag = line_tags[slot];

  fe_tag_policy u_policy (
    .op  (fe_op_e'(req_op)),
    .tag (cur_tag),
    .act (act)
  );

  fe_tag_store #(.LINE_AW(LINE_AW), .SLOTS(SLOTS)) u_tags (
    .clk     (clk),
    .rst     (rst),
    .rd_line (line),
    .rd_tags (line_tags),
    .wr_en   (req_valid && act.tag_we),
    .wr_line (line),
    .wr_slot (slot),
    .wr_val  (act.tag_val),
    .flat    (tag_flat)
  );

  fe_data_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .en    (req_valid),
    .we    (req_valid && act.data_we),
    .addr  (req_addr),
    .wdata (req_wdata),
    .rdata (rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_trap      <= 1'b0;
      rsp_cause     <= CAUSE_NONE;
      rsp_line_tags <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_trap      <= act.trap;
        rsp_cause     <= act.cause;
        rsp_line_tags <= line_tags;
      end
    end
  end
endmodule

// File: rtl/fe_sync_mem_chk.sv
module fe_sync_mem_chk #(
  parameter int ADDR_W = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic [2:0]            req_op,
  input logic [ADDR_W-1:0]     req_addr,
  input logic                  rsp_valid,
  input logic                  rsp_trap,
  input logic [1:0]            rsp_cause,
  input logic                  cur_tag,
  input logic [(1<<ADDR_W)-1:0] tag_flat
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R1
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R1
  AST_CAUSE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !rsp_trap |-> rsp_cause == 2'd0); // R9
  AST_CAUSE_SET: assert property (@(posedge clk) disable iff (rst)
    rsp_trap |-> rsp_cause != 2'd0); // R9
  AST_PLAIN_KEEPS_TAG: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_op == 3'd0 || req_op == 3'd1)) |=> tag_flat[$past(req_addr)] == $past(cur_tag)); // R3
  AST_TAKE_EMPTY_TRAP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd3 && !cur_tag) |=> rsp_trap && rsp_cause == 2'd1); // R5
  AST_FILL_SETS_TAG: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd4) |=> tag_flat[$past(req_addr)]); // R6
  AST_FILLCHK_FULL_TRAP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd5 && cur_tag) |=> rsp_trap && rsp_cause == 2'd2); // R7
  AST_TRAP_KEEPS_TAG: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_trap) |-> tag_flat[$past(req_addr)] == $past(cur_tag)); // R8
  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op[2:1] == 2'b11) |=> !rsp_trap && tag_flat[$past(req_addr)] == $past(cur_tag)); // R11
endmodule

bind fe_sync_mem fe_sync_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_trap  (rsp_trap),
  .rsp_cause (rsp_cause),
  .cur_tag   (cur_tag),
  .tag_flat  (tag_flat)
);

// File: tb/fe_sync_mem_test.sv
module fe_sync_mem_test;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int NV = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid, rsp_trap;
  logic [DW-1:0] rsp_rdata;
  logic [1:0] rsp_cause;
  logic [3:0] rsp_line_tags;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fe_sync_mem #(.DATA_W(DW), .ADDR_W(AW), .SLOTS(4)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_trap(rsp_trap), .rsp_cause(rsp_cause),
    .rsp_line_tags(rsp_line_tags)
  );

  // {op, addr, wdata, trap, cause, line_tags_before, rdata, check_rdata, req}
  localparam logic [84:0] VEC [NV] = '{
    {3'd1, 6'd5,  32'h11111111, 1'b0, 2'd0, 4'b0000, 32'h00000000, 1'b0, 4'd3},  // R3 plain store
    {3'd2, 6'd5,  32'h0,        1'b1, 2'd1, 4'b0000, 32'h11111111, 1'b1, 4'd4},  // R4 empty traps, word returned
    {3'd5, 6'd5,  32'h22222222, 1'b0, 2'd0, 4'b0000, 32'h11111111, 1'b1, 4'd7},  // R7 fill on empty
    {3'd2, 6'd5,  32'h0,        1'b0, 2'd0, 4'b0010, 32'h22222222, 1'b1, 4'd4},  // R4 full ok
    {3'd5, 6'd5,  32'h33333333, 1'b1, 2'd2, 4'b0010, 32'h22222222, 1'b1, 4'd7},  // R7 full traps
    {3'd0, 6'd5,  32'h0,        1'b0, 2'd0, 4'b0010, 32'h22222222, 1'b1, 4'd8},  // R8 trapped store wrote nothing
    {3'd3, 6'd5,  32'h0,        1'b0, 2'd0, 4'b0010, 32'h22222222, 1'b1, 4'd5},  // R5 take full; R3 load kept tag
    {3'd3, 6'd5,  32'h0,        1'b1, 2'd1, 4'b0000, 32'h22222222, 1'b1, 4'd5},  // R5 take empty traps
    {3'd4, 6'd5,  32'h44444444, 1'b0, 2'd0, 4'b0000, 32'h22222222, 1'b1, 4'd12}, // R12 store returns old
    {3'd4, 6'd5,  32'h55555555, 1'b0, 2'd0, 4'b0010, 32'h44444444, 1'b1, 4'd6},  // R6 unconditional on full
    {3'd3, 6'd5,  32'h0,        1'b0, 2'd0, 4'b0010, 32'h55555555, 1'b1, 4'd6},  // R6 second fill wrote
    {3'd1, 6'd5,  32'h66666666, 1'b0, 2'd0, 4'b0000, 32'h55555555, 1'b1, 4'd3},  // R3 plain store on empty
    {3'd2, 6'd5,  32'h0,        1'b1, 2'd1, 4'b0000, 32'h66666666, 1'b1, 4'd3},  // R3 stays empty
    {3'd4, 6'd6,  32'h77777777, 1'b0, 2'd0, 4'b0000, 32'h00000000, 1'b0, 4'd10}, // R10 neighbour
    {3'd2, 6'd5,  32'h0,        1'b1, 2'd1, 4'b0100, 32'h66666666, 1'b1, 4'd10}, // R10 bit2 only
    {3'd7, 6'd6,  32'h99999999, 1'b0, 2'd0, 4'b0100, 32'h77777777, 1'b1, 4'd11}, // R11 reserved
    {3'd6, 6'd6,  32'h99999999, 1'b0, 2'd0, 4'b0100, 32'h77777777, 1'b1, 4'd11}, // R11 reserved
    {3'd2, 6'd6,  32'h0,        1'b0, 2'd0, 4'b0100, 32'h77777777, 1'b1, 4'd11}, // R11 nothing changed
    {3'd1, 6'd6,  32'h88888888, 1'b0, 2'd0, 4'b0100, 32'h77777777, 1'b1, 4'd3},  // R3 plain store on full
    {3'd0, 6'd6,  32'h0,        1'b0, 2'd0, 4'b0100, 32'h88888888, 1'b1, 4'd3},  // R3 still full
    {3'd4, 6'd63, 32'hDEADBEEF, 1'b0, 2'd0, 4'b0000, 32'h00000000, 1'b0, 4'd6},  // R6 top word
    {3'd3, 6'd63, 32'h0,        1'b0, 2'd0, 4'b1000, 32'hDEADBEEF, 1'b1, 4'd10}, // R10 bit3
    {3'd5, 6'd0,  32'h0BADF00D, 1'b0, 2'd0, 4'b0000, 32'h00000000, 1'b0, 4'd7},  // R7 word zero
    {3'd2, 6'd0,  32'h0,        1'b0, 2'd0, 4'b0001, 32'h0BADF00D, 1'b1, 4'd10}  // R10 bit0
  };

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    chk("R2 rsp_trap in reset", {31'd0, rsp_trap}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [84:0] v;
      string t;
      v = VEC[i];
      access(v[84:82], v[81:76], v[75:44]);
      t = $sformatf("R%0d vec%0d", v[3:0], i);
      chk({t, " valid"}, {31'd0, rsp_valid}, 32'd1);
      chk({t, " trap"},  {31'd0, rsp_trap},  {31'd0, v[43]});
      chk({t, " cause"}, {30'd0, rsp_cause}, {30'd0, v[42:41]});
      chk({t, " tags"},  {28'd0, rsp_line_tags}, {28'd0, v[40:37]});
      if (v[4]) chk({t, " rdata"}, rsp_rdata, v[36:5]);
    end

    // R1: idle cycle gives no response
    @(negedge clk);
    chk("R1 idle no response", {31'd0, rsp_valid}, 32'd0);

    // R9: back-to-back trap then clean response clears the cause
    access(3'd3, 6'd63, 32'h0);
    chk("R9 trap cause empty", {30'd0, rsp_cause}, 32'd1);
    access(3'd0, 6'd63, 32'h0);
    chk("R9 cause cleared", {30'd0, rsp_cause}, 32'd0);

    // R2: reset empties tags that were full (word 0 and word 6)
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    access(3'd2, 6'd0, 32'h0);
    chk("R2 word0 empty after reset trap", {31'd0, rsp_trap}, 32'd1);
    chk("R2 line0 tags cleared", {28'd0, rsp_line_tags}, 32'd0);
    access(3'd2, 6'd6, 32'h0);
    chk("R2 line1 tags cleared", {28'd0, rsp_line_tags}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule